// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. It has three 16-bit registers: a control register, the 8-bit count and a reset control register. Each write counts only when its upper byte carries the key for that register. A wrong key leaves every bit of state as it was. The counter counts upward. It advances once per tick from a prescaler, and the control register picks the prescale divisor. When the counter wraps from 255 to 0 in watchdog mode, the block sets a sticky overflow flag. If the reset enable is also set, it drives a system reset pulse of fixed length.

Software keeps the system alive by reloading the counter with zero before the count wraps. It can force a fast reset by loading 255 with the fastest prescale selected. The overflow flag is cleared in two steps: a read strobe on the reset control register while the flag is set, followed by the exact clear word. Read data is combinational from the byte address. The read strobe only marks that a read happened, which the clear handshake needs.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the registers at offsets 0, 2 and 4 all read 0x0000 and the reset output is low.
- R2: A write to offset 0 with upper byte 0xA5 stores bit 6 (watchdog mode), bit 5 (run) and bits 2:0 (divisor select). Offset 0 reads these bits back in the same positions, with every other bit zero.
- R3: A write to offset 2 with upper byte 0x5A loads the lower byte into the counter. A load takes priority over a count in the same cycle. Offset 2 reads the counter in bits 7:0.
- R4: A write to offset 4 with upper byte 0x5A updates the reset enable from bit 6 and leaves the overflow flag unchanged. Offset 4 reads the flag in bit 7 and the reset enable in bit 6.
- R5: The following writes change no state: any write whose upper byte is not that register's key, any write to an address other than 0, 2 or 4, and any write of 0xA5xx to offset 4 other than 0xA500. Reads of other addresses return 0, and the upper byte of every read is 0.
- R6: While run is set, the counter advances by one every N clocks. N is 1, 64, 128, 256, 512, 1024, 4096 or 16384 for select values 0 to 7. The prescale phase restarts when run is clear, so the first count comes N clocks after run is set.
- R7: While run is clear and no load occurs, the counter holds its value.
- R8: A count from 255 wraps to 0. In watchdog mode the wrap sets the overflow flag. With watchdog mode clear, the wrap sets no flag and starts no reset.
- R9: A wrap in watchdog mode with the reset enable set raises the reset output one clock after the counting edge. The output then stays high for exactly 32 clocks. With the reset enable clear, no pulse starts.
- R10: A write of exactly 0xA500 to offset 4 clears the overflow flag only when a read strobe at offset 4 was seen while the flag was set. Without that read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Byte address of the register |
| bus_wdata | input | 16 | Write data, key in bits 15:8 |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, marks a read for the flag handshake |
| bus_rdata | output | 16 | Read data of the addressed register |
| wdt_rst_out | output | 1 | System reset pulse |

## Verification
Most internal faults show up at the ports within a few clocks. A wrong key decode or wrong field placement shows in the readback of the very next cycle. A prescale phase that is off by one moves the first count by one clock. The bench samples on exactly the clock where the first count is expected, and on the clock before it. A flag or pulse fault shows on the clock after the wrapping edge. A pulse of the wrong length shows on the 32nd or 33rd clock after it. A handshake fault shows as a flag that clears without a prior read, or that refuses to clear after one.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int CNT_W = 8;
    localparam int PS_W  = 14;
    localparam int BUS_W = 16;

    localparam logic [2:0] OFS_CTL = 3'd0;
    localparam logic [2:0] OFS_CNT = 3'd2;
    localparam logic [2:0] OFS_RST = 3'd4;

    localparam logic [7:0]  KEY_CTL   = 8'hA5;
    localparam logic [7:0]  KEY_CNT   = 8'h5A;
    localparam logic [7:0]  KEY_RST   = 8'h5A;
    localparam logic [15:0] CLR_WORD  = 16'hA500;

    typedef struct packed {
        logic       mode;
        logic       run;
        logic [2:0] sel;
    } ctl_t;

    // last prescale phase for each select value (divisor minus one)
    function automatic logic [PS_W-1:0] sel_limit(input logic [2:0] sel);
        logic [PS_W-1:0] lim;
        case (sel)
            3'd0:    lim = PS_W'(0);
            3'd1:    lim = PS_W'(63);
            3'd2:    lim = PS_W'(127);
            3'd3:    lim = PS_W'(255);
            3'd4:    lim = PS_W'(511);
            3'd5:    lim = PS_W'(1023);
            3'd6:    lim = PS_W'(4095);
            default: lim = PS_W'(16383);
        endcase
        return lim;
    endfunction
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              ovf_i,
    output ctl_t              ctl_o,
    output logic              rste_o,
    output logic              ld_o,
    output logic [CNT_W-1:0]  ld_val_o,
    output logic              clr_o,
    output logic              rd_flag_o,
    output logic [BUS_W-1:0]  rdata_o
);
    typedef struct packed {
        ctl_t ctl;
        logic rste;
    } regs_s;

    regs_s s_d, s_q;

    logic hit_ctl, hit_cnt, hit_rst;

    always_comb begin
        s_d     = s_q;
        hit_ctl = we_i && addr_i == OFS_CTL && wdata_i[15:8] == KEY_CTL;
        hit_cnt = we_i && addr_i == OFS_CNT && wdata_i[15:8] == KEY_CNT;
        hit_rst = we_i && addr_i == OFS_RST && wdata_i[15:8] == KEY_RST;
        if (hit_ctl) begin
            s_d.ctl.mode = wdata_i[6];
            s_d.ctl.run  = wdata_i[5];
            s_d.ctl.sel  = wdata_i[2:0];
        end
        if (hit_rst) s_d.rste = wdata_i[6];
        ld_o      = hit_cnt;
        ld_val_o  = wdata_i[CNT_W-1:0];
        clr_o     = we_i && addr_i == OFS_RST && wdata_i == CLR_WORD;
        rd_flag_o = re_i && addr_i == OFS_RST;
        case (addr_i)
            OFS_CTL: rdata_o = {8'h00, 1'b0, s_q.ctl.mode, s_q.ctl.run, 2'b00, s_q.ctl.sel};
            OFS_CNT: rdata_o = {8'h00, cnt_i};
            OFS_RST: rdata_o = {8'h00, ovf_i, s_q.rste, 6'b000000};
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o  = s_q.ctl;
    assign rste_o = s_q.rste;

    // R5
    ctl_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wdata_i[15:8] != KEY_CTL) |=> $stable(s_q.ctl));
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale
    import kwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);
    typedef struct packed {
        logic [PS_W-1:0] phase;
    } ps_s;

    ps_s s_d, s_q;
    logic [PS_W-1:0] lim;

    always_comb begin
        s_d    = s_q;
        lim    = sel_limit(sel_i);
        tick_o = run_i && (s_q.phase >= lim);
        if (!run_i)      s_d.phase = '0;
        else if (tick_o) s_d.phase = '0;
        else             s_d.phase = s_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && sel_i != 3'd0) |=> (!tick_o || sel_i == 3'd0));
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int PULSE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             run_i,
    input  logic             rste_i,
    input  logic             tick_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             clr_i,
    input  logic             rd_flag_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             rst_o
);
    localparam int PL_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             armed;
        logic [PL_W-1:0]  pulse;
    } core_s;

    core_s s_d, s_q;
    logic  wrap;

    always_comb begin
        s_d  = s_q;
        wrap = run_i && tick_i && !ld_i && s_q.cnt == CNT_MAX;
        if (ld_i)                 s_d.cnt = ld_val_i;
        else if (run_i && tick_i) s_d.cnt = s_q.cnt + 1'b1;

        if (wrap && mode_i) begin
            s_d.ovf   = 1'b1;
            s_d.armed = 1'b0;
        end else if (clr_i && s_q.armed) begin
            s_d.ovf   = 1'b0;
            s_d.armed = 1'b0;
        end else if (rd_flag_i && s_q.ovf) begin
            s_d.armed = 1'b1;
        end

        if (wrap && mode_i && rste_i) s_d.pulse = PL_W'(PULSE_LEN);
        else if (s_q.pulse != '0)     s_d.pulse = s_q.pulse - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign ovf_o = s_q.ovf;
    assign rst_o = s_q.pulse != '0;

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && !(run_i && tick_i)) |=> $stable(s_q.cnt));
    // R8
    flag_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ovf) |-> $past(mode_i));
    // R9
    pulse_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> $past(rste_i));
    // R10
    clear_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.ovf) |-> $past(s_q.armed));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int PULSE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_we,
    input  logic        bus_re,
    output logic [15:0] bus_rdata,
    output logic        wdt_rst_out
);
    ctl_t             ctl;
    logic             rste, ld, clr, rd_flag, tick, ovf;
    logic [CNT_W-1:0] ld_val, cnt;

    kwdt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .we_i(bus_we), .re_i(bus_re), .cnt_i(cnt), .ovf_i(ovf),
        .ctl_o(ctl), .rste_o(rste), .ld_o(ld), .ld_val_o(ld_val),
        .clr_o(clr), .rd_flag_o(rd_flag), .rdata_o(bus_rdata)
    );

    kwdt_prescale u_ps (
        .clk(clk), .rst_n(rst_n), .run_i(ctl.run), .sel_i(ctl.sel), .tick_o(tick)
    );

    kwdt_core #(.PULSE_LEN(PULSE_LEN)) u_core (
        .clk(clk), .rst_n(rst_n), .mode_i(ctl.mode), .run_i(ctl.run),
        .rste_i(rste), .tick_i(tick), .ld_i(ld), .ld_val_i(ld_val),
        .clr_i(clr), .rd_flag_i(rd_flag), .cnt_o(cnt), .ovf_o(ovf),
        .rst_o(wdt_rst_out)
    );
endmodule

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;
    logic        wdt_rst_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    kwdt_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .wdt_rst_out(wdt_rst_out)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // {write addr, write data, read addr, expected read}
    localparam int NV = 11;
    localparam logic [37:0] VEC [NV] = '{
        {3'd0, 16'hA547, 3'd0, 16'h0047},   // R2
        {3'd0, 16'h5AFF, 3'd0, 16'h0047},   // R5 wrong key
        {3'd2, 16'h5A3C, 3'd2, 16'h003C},   // R3
        {3'd2, 16'hA511, 3'd2, 16'h003C},   // R5 wrong key
        {3'd4, 16'h5A40, 3'd4, 16'h0040},   // R4
        {3'd4, 16'hA540, 3'd4, 16'h0040},   // R5 not the clear word
        {3'd4, 16'h5A00, 3'd4, 16'h0000},   // R4
        {3'd6, 16'h5AFF, 3'd2, 16'h003C},   // R5 unused address
        {3'd0, 16'hA5FF, 3'd0, 16'h0067},   // R2 unused bits dropped
        {3'd0, 16'hA500, 3'd0, 16'h0000},   // R2
        {3'd2, 16'hA500, 3'd6, 16'h0000}    // R5 unused read
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic run_clocks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(3'd0, v); check("R1 ctl", v, 16'h0000);
        peek(3'd2, v); check("R1 cnt", v, 16'h0000);
        peek(3'd4, v); check("R1 rst", v, 16'h0000);
        check("R1 rst_out", {15'd0, wdt_rst_out}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][37:35], VEC[i][34:19]);
            peek(VEC[i][18:16], v);
            check($sformatf("vector %0d (R2 R3 R4 R5)", i), v, VEC[i][15:0]);
        end

        // R6 select 0: one count per clock
        wr(3'd2, 16'h5A00);
        wr(3'd0, 16'hA520);
        run_clocks(10);
        peek(3'd2, v); check("R6 sel0 count", v, 16'h000A);
        // R7 stop: the stopping edge still counts once
        wr(3'd0, 16'hA500);
        run_clocks(20);
        peek(3'd2, v); check("R7 hold", v, 16'h000B);

        // R6 select 1: 64 clocks per count
        wr(3'd2, 16'h5A00);
        wr(3'd0, 16'hA521);
        run_clocks(63);
        peek(3'd2, v); check("R6 sel1 before", v, 16'h0000);
        run_clocks(1);
        peek(3'd2, v); check("R6 sel1 first", v, 16'h0001);
        wr(3'd0, 16'hA500);

        // R6 select 7: 16384 clocks per count
        wr(3'd2, 16'h5A00);
        wr(3'd0, 16'hA527);
        run_clocks(16383);
        peek(3'd2, v); check("R6 sel7 before", v, 16'h0000);
        run_clocks(1);
        peek(3'd2, v); check("R6 sel7 first", v, 16'h0001);
        wr(3'd0, 16'hA500);

        // R8 interval mode wrap: no flag, no reset
        wr(3'd4, 16'h5A40);
        wr(3'd2, 16'h5AFF);
        wr(3'd0, 16'hA520);
        run_clocks(1);
        peek(3'd2, v); check("R8 wrap to zero", v, 16'h0000);
        peek(3'd4, v); check("R8 no flag in interval mode", v, 16'h0040);
        check("R9 no pulse in interval mode", {15'd0, wdt_rst_out}, 16'd0);
        wr(3'd0, 16'hA500);

        // R9 watchdog mode, reset disabled
        wr(3'd4, 16'h5A00);
        wr(3'd2, 16'h5AFF);
        wr(3'd0, 16'hA560);
        run_clocks(1);
        peek(3'd4, v); check("R8 flag set", v, 16'h0080);
        check("R9 no pulse without enable", {15'd0, wdt_rst_out}, 16'd0);
        wr(3'd0, 16'hA500);
        rd(3'd4);
        wr(3'd4, 16'hA500);
        peek(3'd4, v); check("R10 clear after read", v, 16'h0000);

        // R9 watchdog mode, reset enabled
        wr(3'd4, 16'h5A40);
        wr(3'd2, 16'h5AFF);
        wr(3'd0, 16'hA560);
        check("R9 low before wrap", {15'd0, wdt_rst_out}, 16'd0);
        run_clocks(1);
        check("R9 pulse start", {15'd0, wdt_rst_out}, 16'd1);
        peek(3'd4, v); check("R8 flag and enable", v, 16'h00C0);
        run_clocks(31);
        check("R9 pulse clock 32", {15'd0, wdt_rst_out}, 16'd1);
        run_clocks(1);
        check("R9 pulse ended", {15'd0, wdt_rst_out}, 16'd0);
        wr(3'd0, 16'hA500);

        // R10 handshake
        wr(3'd4, 16'hA500);
        peek(3'd4, v); check("R10 no clear without read", v, 16'h00C0);
        wr(3'd4, 16'h5A00);
        peek(3'd4, v); check("R4 enable write keeps flag", v, 16'h0080);
        rd(3'd4);
        wr(3'd4, 16'hA501);
        peek(3'd4, v); check("R5 near clear word ignored", v, 16'h0080);
        wr(3'd4, 16'hA500);
        peek(3'd4, v); check("R10 clear after read", v, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule